// File: doc/BRIEF.md
# Secondary Bus Two-Level Rotating Arbiter

This block decides which of five masters may drive a downstream parallel bus. Requester 0 is the bridge itself and requesters 1 to 4 are external masters. Each requester has an active-low request input and an active-low grant output. A priority input puts each requester in either a high group or a low group. Each group takes turns round-robin, and the low group as a whole fills one turn in the high-group rotation.

The arbiter watches the frame and initiator-ready lines to tell an idle bus from a busy one.

- **Busy bus:** the grant may pass straight to the next master while the current transaction drains.
- **Idle bus:** a grant is always removed one clock before any other grant appears.
- **Timeout:** a requesting master that holds the grant on an idle bus without ever starting a transaction loses the grant after a fixed number of cycles.
- **No requests:** the grant is parked on the bridge.
- **Disabled:** a disable input forces every grant high so that an arbiter outside the block can run the bus.

Top module: `sec_arbiter`

## Requirements
- R1: After a cycle with `rst` high, every bit of `gnt_n` is 1. On the first enabled clock after reset, the grant goes to requester 0, which drives `gnt_n` to 5'b11110.
- R2: At most one bit of `gnt_n` is 0 at any time.
- R3: With no request pending and the arbiter enabled, the grant is parked on requester 0 (bit 0 of `gnt_n` low).
- R4: While the bus is idle (`frame_n` and `irdy_n` both high), a change of grant from one requester to another passes through at least one cycle in which all grants are high.
- R5: A master counts as having started once the bus turns busy after an idle cycle. On a busy bus, once the current holder has started or has dropped its request, the grant moves directly to the next winner with no all-high cycle in between.
- R6: A holder that is still requesting and has not yet started keeps its grant, whether the bus is idle or busy.
- R7: If the holder keeps requesting but the bus stays idle for TIMEOUT consecutive granted cycles (16 by default), its grant is removed on the next clock edge.
- R8: Within the high group (bit set in `prio_high`), the next winner is the first requester after the last high-group winner, in ascending index order with wrap-around.
- R9: All low-group requesters together take one slot, placed after index N_REQ-1 in the high-group rotation. Inside that slot, low-group requesters rotate round-robin after the last low-group winner.
- R10: While `arb_disable` is high, every bit of `gnt_n` is 1 from the next clock on, and requests are ignored. When `arb_disable` returns low, arbitration resumes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_disable | input | 1 | High turns the arbiter off; all grants go high |
| prio_high | input | N_REQ | One bit per requester: 1 places it in the high group, 0 in the low group |
| req_n | input | N_REQ | Active-low requests; bit 0 is the bridge |
| frame_n | input | 1 | Active-low bus frame signal |
| irdy_n | input | 1 | Active-low initiator-ready signal |
| gnt_n | output | N_REQ | Active-low registered grants |

## Verification
The bench builds the block with its default values: five requesters and a 16-cycle timeout. With these values both rotation levels can be exercised fully, and the timeout expiry can be reached within a few dozen cycles. Two priority setups are used. With every requester in the high group, the bench checks the plain rotation, busy-bus handoff, the idle gap and the timeout. With a split of two high and three low requesters, it checks that the low group behaves as a single interleaved slot.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Decision taken by the arbiter at each clock edge.
  typedef enum logic [2:0] {
    ACT_OFF,    // disabled: no grant
    ACT_GRANT,  // no grant out: issue winner
    ACT_HOLD,   // keep current holder
    ACT_MOVE,   // busy bus: move grant without gap
    ACT_DROP    // idle bus: remove grant (gap or timeout)
  } arb_act_e;

endpackage

// File: rtl/rr_pick.sv
// Round-robin selector: first set bit after index `last`, with wrap-around.
module rr_pick #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] idx,
  output logic          found
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= W; k++) begin
      int c;
      c = (int'(last) + k) % W;
      if (!found && vec[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end

endmodule

// File: rtl/two_level_pick.sv
// Two-level winner selection: high group rotates with one extra slot that
// stands for the whole low group, which rotates on its own pointer.
module two_level_pick #(
  parameter int N_REQ = 5,
  localparam int IW   = $clog2(N_REQ),
  localparam int SW   = $clog2(N_REQ + 1)
) (
  input  logic [N_REQ-1:0] req,
  input  logic [N_REQ-1:0] prio_high,
  input  logic [SW-1:0]    hi_last,
  input  logic [IW-1:0]    lo_last,
  output logic [IW-1:0]    win_idx,
  output logic             win_any,
  output logic [SW-1:0]    nxt_hi,
  output logic [IW-1:0]    nxt_lo
);

  logic [N_REQ:0]   hi_vec;
  logic [N_REQ-1:0] lo_vec;
  logic [SW-1:0]    hi_idx;
  logic [IW-1:0]    lo_idx;
  logic             hi_found;
  logic             lo_found;
  logic             low_slot;

  assign lo_vec = req & ~prio_high;
  assign hi_vec = {|lo_vec, req & prio_high};

  rr_pick #(.W(N_REQ + 1), .IW(SW)) u_hi (
    .vec   (hi_vec),
    .last  (hi_last),
    .idx   (hi_idx),
    .found (hi_found)
  );

  rr_pick #(.W(N_REQ), .IW(IW)) u_lo (
    .vec   (lo_vec),
    .last  (lo_last),
    .idx   (lo_idx),
    .found (lo_found)
  );

  assign low_slot = hi_found && (hi_idx == SW'(N_REQ));
  assign win_any  = hi_found && (!low_slot || lo_found);

  always_comb begin
    win_idx = '0;
    nxt_hi  = hi_last;
    nxt_lo  = lo_last;
    if (win_any) begin
      if (low_slot) begin
        win_idx = lo_idx;
        nxt_hi  = SW'(N_REQ);
        nxt_lo  = lo_idx;
      end else begin
        win_idx = IW'(hi_idx);
        nxt_hi  = hi_idx;
      end
    end
  end

endmodule

// File: rtl/bus_watch.sv
// Bus state tracking: idle flag and start-of-transaction pulse.
module bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  output logic idle,
  output logic start
);

  logic idle_prev_q;

  assign idle  = frame_n & irdy_n;
  assign start = !idle && idle_prev_q;

  always_ff @(posedge clk) begin
    if (rst) idle_prev_q <= 1'b1;
    else     idle_prev_q <= idle;
  end

endmodule

// File: rtl/grant_timer.sv
// Counts idle granted cycles of a requesting holder; flags the last one.
module grant_timer #(
  parameter int TIMEOUT = 16,
  localparam int CW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic last
);

  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == CW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sec_arbiter.sv
module sec_arbiter
  import arb_pkg::*;
#(
  parameter int N_REQ   = 5,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arb_disable,
  input  logic [N_REQ-1:0] prio_high,
  input  logic [N_REQ-1:0] req_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic [N_REQ-1:0] gnt_n
);

  localparam int IW = $clog2(N_REQ);
  localparam int SW = $clog2(N_REQ + 1);

  logic [N_REQ-1:0] req;
  logic             granted_q, granted_d;
  logic [IW-1:0]    holder_q, holder_d;
  logic             used_q, used_d;
  logic [SW-1:0]    hi_last_q;
  logic [IW-1:0]    lo_last_q;
  logic [N_REQ-1:0] gnt_n_q;

  logic [IW-1:0]    win_idx;
  logic             win_any;
  logic [SW-1:0]    nxt_hi;
  logic [IW-1:0]    nxt_lo;
  logic             idle, start;
  logic             hold_req, used_eff, to_last, tick, tclr;
  arb_act_e         act;

  assign req      = ~req_n;
  assign hold_req = req[holder_q];
  assign used_eff = used_q | start;

  two_level_pick #(.N_REQ(N_REQ)) u_pick (
    .req       (req),
    .prio_high (prio_high),
    .hi_last   (hi_last_q),
    .lo_last   (lo_last_q),
    .win_idx   (win_idx),
    .win_any   (win_any),
    .nxt_hi    (nxt_hi),
    .nxt_lo    (nxt_lo)
  );

  bus_watch u_bus (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .idle    (idle),
    .start   (start)
  );

  // Decision for this edge
  always_comb begin
    if (arb_disable) begin
      act = ACT_OFF;
    end else if (!granted_q) begin
      act = ACT_GRANT;
    end else if (!idle) begin
      if ((used_eff || !hold_req) && (win_idx != holder_q)) act = ACT_MOVE;
      else                                                   act = ACT_HOLD;
    end else if (hold_req && to_last) begin
      act = ACT_DROP;
    end else if ((used_q || !hold_req) && (win_idx != holder_q)) begin
      act = ACT_DROP;
    end else begin
      act = ACT_HOLD;
    end
  end

  assign tick = granted_q && idle && hold_req && !arb_disable;
  assign tclr = !tick || (act != ACT_HOLD);

  grant_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (tclr),
    .tick  (tick),
    .last  (to_last)
  );

  always_comb begin
    granted_d = granted_q;
    holder_d  = holder_q;
    used_d    = used_q;
    unique case (act)
      ACT_OFF, ACT_DROP: begin
        granted_d = 1'b0;
        used_d    = 1'b0;
      end
      ACT_GRANT, ACT_MOVE: begin
        granted_d = 1'b1;
        holder_d  = win_idx;
        used_d    = 1'b0;
      end
      default: used_d = used_eff;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      granted_q <= 1'b0;
      holder_q  <= '0;
      used_q    <= 1'b0;
      hi_last_q <= SW'(N_REQ);
      lo_last_q <= IW'(N_REQ - 1);
    end else begin
      granted_q <= granted_d;
      holder_q  <= holder_d;
      used_q    <= used_d;
      if ((act == ACT_GRANT || act == ACT_MOVE) && win_any) begin
        hi_last_q <= nxt_hi;
        lo_last_q <= nxt_lo;
      end
    end
  end

  // Registered active-low grant outputs, one flop per requester
  for (genvar i = 0; i < N_REQ; i++) begin : g_gnt
    always_ff @(posedge clk) begin
      if (rst) gnt_n_q[i] <= 1'b1;
      else     gnt_n_q[i] <= !(granted_d && (holder_d == IW'(i)));
    end
  end

  assign gnt_n = gnt_n_q;

endmodule

// File: rtl/sec_arbiter_chk.sv
module sec_arbiter_chk #(
  parameter int N_REQ   = 5,
  parameter int TIMEOUT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             arb_disable,
  input logic [N_REQ-1:0] req_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic [N_REQ-1:0] gnt_n
);

  localparam int RW = $clog2(TIMEOUT + 2) + 1;

  logic [N_REQ-1:0] gnt_prev_q;
  logic [RW-1:0]    run_q;
  logic             stall;

  assign stall = !arb_disable && frame_n && irdy_n && ((~req_n & ~gnt_n) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_prev_q <= '1;
      run_q      <= '0;
    end else begin
      gnt_prev_q <= gnt_n;
      if (!stall)                   run_q <= '0;
      else if (gnt_n != gnt_prev_q) run_q <= RW'(1);
      else                          run_q <= run_q + 1'b1;
    end
  end

  AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> (&gnt_n)); // R1

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gnt_n)); // R2

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    (!arb_disable && frame_n && irdy_n && !(&gnt_n))
      |=> ((gnt_n == $past(gnt_n)) || (&gnt_n))); // R4

  AST_STALL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(TIMEOUT)); // R7

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    arb_disable |=> (&gnt_n)); // R10

endmodule

bind sec_arbiter sec_arbiter_chk #(.N_REQ(N_REQ), .TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .arb_disable (arb_disable),
  .req_n       (req_n),
  .frame_n     (frame_n),
  .irdy_n      (irdy_n),
  .gnt_n       (gnt_n)
);

// File: tb/sec_arbiter_tb.sv
module sec_arbiter_tb;

  localparam int N = 5;

  typedef struct {
    logic [N-1:0] exp;
    bit           chk;
    string        rid;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         arb_disable = 1'b0;
  logic [N-1:0] prio_high = '1;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic [N-1:0] gnt_n;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sec_arbiter #(.N_REQ(N), .TIMEOUT(16)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .arb_disable (arb_disable),
    .prio_high   (prio_high),
    .req_n       (req_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .gnt_n       (gnt_n)
  );

  // Driver: one bus cycle of stimulus plus the grant expected after the edge
  task automatic cyc(input logic r, input logic d, input logic [N-1:0] rq,
                     input logic fr, input logic ir, input logic [N-1:0] exp,
                     input bit chk, input string rid);
    item_t it;
    @(negedge clk);
    rst = r; arb_disable = d; req_n = rq; frame_n = fr; irdy_n = ir;
    it.exp = exp; it.chk = chk; it.rid = rid;
    q.push_back(it);
  endtask

  // Monitor: compares mid-high phase after each edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (!rst) begin
        checks++;
        if ($countones(~gnt_n) > 1) begin
          errors++;
          $display("FAIL R2: gnt_n=%b expected at most one low bit", gnt_n);
        end
      end
      if (it.chk) begin
        checks++;
        if (gnt_n !== it.exp) begin
          errors++;
          $display("FAIL %s: gnt_n=%b expected %b", it.rid, gnt_n, it.exp);
        end
      end
    end
  end

  initial begin
    // Scenario A: every requester in the high group
    prio_high = 5'b11111;
    cyc(1, 0, 5'b11111, 1, 1, 5'b11111, 1, "R1");
    cyc(1, 0, 5'b11111, 1, 1, 5'b11111, 1, "R1");
    cyc(0, 0, 5'b11111, 1, 1, 5'b11110, 1, "R1");
    cyc(0, 0, 5'b11111, 1, 1, 5'b11110, 1, "R3");
    cyc(0, 0, 5'b11011, 1, 1, 5'b11111, 1, "R4");   // idle gap before grant moves
    cyc(0, 0, 5'b11011, 1, 1, 5'b11011, 1, "R8");   // requester 2 granted
    cyc(0, 0, 5'b10001, 0, 1, 5'b10111, 1, "R5");   // 2 starts, grant to 3 without gap
    cyc(0, 0, 5'b10001, 0, 1, 5'b10111, 1, "R6");
    cyc(0, 0, 5'b10001, 1, 0, 5'b10111, 1, "R6");
    cyc(0, 0, 5'b10001, 1, 1, 5'b10111, 1, "R6");
    cyc(0, 0, 5'b10001, 0, 1, 5'b11101, 1, "R8");   // 3 starts, wrap to 1
    // R7: holder 1 never starts on an idle bus
    for (int i = 1; i <= 15; i++)
      cyc(0, 0, 5'b11101, 1, 1, 5'b11101, (i == 15), "R7");
    cyc(0, 0, 5'b11101, 1, 1, 5'b11111, 1, "R7");
    cyc(0, 0, 5'b11101, 1, 1, 5'b11101, 1, "R7");
    // R10: disable ignores all requests
    cyc(0, 1, 5'b00000, 1, 1, 5'b11111, 1, "R10");
    cyc(0, 1, 5'b00000, 0, 1, 5'b11111, 1, "R10");
    cyc(0, 1, 5'b00000, 1, 1, 5'b11111, 1, "R10");
    cyc(0, 0, 5'b11111, 1, 1, 5'b11110, 1, "R10");
    cyc(0, 0, 5'b11111, 1, 1, 5'b11110, 1, "R3");

    // Scenario B: 0 and 1 high, 2..4 low; requests from 1, 2, 3
    prio_high = 5'b00011;
    cyc(1, 0, 5'b10001, 1, 1, 5'b11111, 1, "R1");
    cyc(0, 0, 5'b10001, 1, 1, 5'b11101, 1, "R9");   // 1
    cyc(0, 0, 5'b10001, 0, 1, 5'b11011, 1, "R9");   // low slot: 2
    cyc(0, 0, 5'b10001, 1, 1, 5'b11011, 1, "R6");
    cyc(0, 0, 5'b10001, 0, 1, 5'b11101, 1, "R9");   // back to 1
    cyc(0, 0, 5'b10001, 1, 1, 5'b11101, 0, "R6");
    cyc(0, 0, 5'b10001, 0, 1, 5'b10111, 1, "R9");   // low slot: 3
    cyc(0, 0, 5'b10001, 1, 1, 5'b10111, 0, "R6");
    cyc(0, 0, 5'b10001, 0, 1, 5'b11101, 1, "R9");   // 1
    cyc(0, 0, 5'b10001, 1, 1, 5'b11101, 0, "R6");
    cyc(0, 0, 5'b10001, 0, 1, 5'b11011, 1, "R9");   // low wraps to 2
    cyc(0, 0, 5'b11111, 1, 1, 5'b11011, 0, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule